// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a power-of-two table of 2-bit saturating counters. A branch selects its counter by XOR-ing a slice of its program counter with a shift register. That register holds the outcomes of the most recently resolved branches. A lookup is purely combinational: the front end presents a PC and receives, in the same cycle, a taken/not-taken guess and the table index that produced it.

When the branch resolves, the back end returns that captured index together with the real outcome. The addressed counter takes one step toward the outcome, and the outcome is shifted into the history. Because the index travels with the branch, history that changed between lookup and resolution cannot redirect the training to the wrong entry.

Each counter is a four-state machine. Its states are `CTR_STRONG_NT` (00), `CTR_WEAK_NT` (01), `CTR_WEAK_T` (10) and `CTR_STRONG_T` (11). A taken outcome makes one transition upward: STRONG_NT→WEAK_NT, WEAK_NT→WEAK_T, WEAK_T→STRONG_T, STRONG_T→STRONG_T. A not-taken outcome makes one transition downward: STRONG_T→WEAK_T, WEAK_T→WEAK_NT, WEAK_NT→STRONG_NT, STRONG_NT→STRONG_NT.

Top module: `gshare_predictor`

## Requirements
- R1: `pred_index` equals `pred_pc[ALIGN +: IDX_W]` XOR the current history, where ALIGN (default 2) low PC bits are skipped; the PC bits above the slice and below ALIGN have no effect.
- R2: `pred_taken` is 1 exactly when the selected counter is in CTR_WEAK_T (10) or CTR_STRONG_T (11).
- R3: An update with `upd_taken`=1 moves the counter at `upd_index` one state up, and CTR_STRONG_T stays in CTR_STRONG_T.
- R4: An update with `upd_taken`=0 moves the counter at `upd_index` one state down, and CTR_STRONG_NT stays in CTR_STRONG_NT.
- R5: After reset every counter is CTR_WEAK_NT (01) and the history is all zeros, so every lookup predicts not-taken with `pred_index` equal to the raw PC slice.
- R6: On every clock edge with `upd_valid`=1, the history shifts left by one, with `upd_taken` entering bit 0 and the oldest bit dropped.
- R7: Training writes the entry named by `upd_index`, regardless of how the history has moved since that index was produced.
- R8: When a lookup and an update address the same entry in one cycle, `pred_taken` reflects the counter value before that update.
- R9: With `upd_valid`=0 neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Guessed direction, 1 = taken |
| pred_index | output | IDX_W | Table index used by this lookup |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_index | input | IDX_W | Index captured at lookup time |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench walks one counter through both saturation ends. A design without the clamp would wrap from STRONG_T to STRONG_NT, or from STRONG_NT to STRONG_T, and flip its guess.

It also places a lookup and an update on the same entry in one cycle. A design that forwards the new value would report the post-update guess a cycle early.

A further test trains an index captured several history shifts earlier. A design that rebuilds the index from the present history would train some other counter.

Finally, idle cycles are interleaved with the training. A design that shifts history without a valid update would show a moved `pred_index` at the next lookup.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    // One training step of a hysteresis counter.
    function automatic ctr_state_e ctr_next(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_WEAK_NT;
        endcase
        return nxt;
    endfunction

    // Guess derived from a counter state.
    function automatic logic ctr_says_taken(input ctr_state_e cur);
        logic t;
        unique case (cur)
            CTR_STRONG_NT, CTR_WEAK_NT: t = 1'b0;
            CTR_WEAK_T, CTR_STRONG_T:   t = 1'b1;
            default:                    t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/gshare_history.sv
module gshare_history #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;
endmodule

// File: rtl/gshare_hash.sv
module gshare_hash #(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] pc_slice,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        assign idx[b] = pc_slice[b] ^ hist[b];
    end
endmodule

// File: rtl/gshare_ctr_table.sv
module gshare_ctr_table
    import gshare_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_state_e       rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    output ctr_state_e       wr_state
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_state_e tbl [DEPTH];

    // Counter state register for every entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_next(tbl[wr_idx], wr_taken);
        end
    end

    // Read ports see the pre-update value.
    always_comb begin
        rd_state = tbl[rd_idx];
        wr_state = tbl[wr_idx];
    end
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int ALIGN = 2,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_index,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_index,
    input  logic             upd_taken
);
    localparam int SLICE_HI = ALIGN + IDX_W;

    logic [IDX_W-1:0] hist_q;
    logic [IDX_W-1:0] pc_slice;
    ctr_state_e       pred_state;
    ctr_state_e       upd_cnt;
    logic             unused_pc_bits;

    assign pc_slice       = pred_pc[SLICE_HI-1:ALIGN];
    assign unused_pc_bits = ^{pred_pc[PC_W-1:SLICE_HI], pred_pc[ALIGN-1:0]};

    gshare_history #(.HIST_W(IDX_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist      (hist_q)
    );

    gshare_hash #(.IDX_W(IDX_W)) u_hash (
        .pc_slice (pc_slice),
        .hist     (hist_q),
        .idx      (pred_index)
    );

    gshare_ctr_table #(.IDX_W(IDX_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_index),
        .rd_state (pred_state),
        .wr_en    (upd_valid),
        .wr_idx   (upd_index),
        .wr_taken (upd_taken),
        .wr_state (upd_cnt)
    );

    always_comb begin
        pred_taken = ctr_says_taken(pred_state);
    end
endmodule

// File: rtl/gshare_checker.sv
module gshare_checker #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pred_taken,
    input logic [IDX_W-1:0] pred_index,
    input logic             upd_valid,
    input logic [IDX_W-1:0] upd_index,
    input logic             upd_taken,
    input logic [1:0]       upd_cnt,
    input logic [IDX_W-1:0] hist
);
    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist == {$past(hist[IDX_W-2:0]), $past(upd_taken)});

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist));

    // R3
    train_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_cnt >= 2'd1)
        |=> (pred_index != $past(upd_index)) || pred_taken);

    // R4
    train_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_cnt <= 2'd2)
        |=> (pred_index != $past(upd_index)) || !pred_taken);

    // R8
    same_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_index == pred_index) |-> pred_taken == upd_cnt[1]);
endmodule

bind gshare_predictor gshare_checker #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_taken (pred_taken),
    .pred_index (pred_index),
    .upd_valid  (upd_valid),
    .upd_index  (upd_index),
    .upd_taken  (upd_taken),
    .upd_cnt    (upd_cnt),
    .hist       (hist_q)
);

// File: tb/sim_gshare_predictor.sv
`timescale 1ns/1ps
module sim_gshare_predictor;
    localparam int PC_W  = 32;
    localparam int ALIGN = 2;
    localparam int IDX_W = 10;
    localparam int DEPTH = 1 << IDX_W;
    localparam int MASK  = DEPTH - 1;

    typedef struct {
        logic             taken;
        logic [IDX_W-1:0] idx;
        string            req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  pred_pc = '0;
    logic             pred_taken;
    logic [IDX_W-1:0] pred_index;
    logic             upd_valid = 1'b0;
    logic [IDX_W-1:0] upd_index = '0;
    logic             upd_taken = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    exp_t sb[$];
    int model_cnt [DEPTH];
    int model_hist = 0;

    always #5 clk = ~clk;

    gshare_predictor #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_index(pred_index), .upd_valid(upd_valid), .upd_index(upd_index),
        .upd_taken(upd_taken)
    );

    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return ((pc >> ALIGN) ^ model_hist) & MASK;
    endfunction

    function automatic logic [PC_W-1:0] pc_for(input int idx, input logic [PC_W-1:0] junk);
        // Upper and alignment bits carry junk that must not matter (R1).
        logic [PC_W-1:0] p;
        p = ((idx ^ model_hist) & MASK) << ALIGN;
        p = p | (junk & ~(PC_W'(MASK) << ALIGN));
        return p;
    endfunction

    // Driver: one cycle of stimulus, expected result queued for the monitor.
    task automatic step(input logic [PC_W-1:0] pc, input logic uv, input int uidx,
                        input logic ut, input string req);
        exp_t e;
        @(negedge clk);
        #1;
        pred_pc   = pc;
        upd_valid = uv;
        upd_index = IDX_W'(uidx);
        upd_taken = ut;
        e.idx   = IDX_W'(idx_of(pc));
        e.taken = (model_cnt[idx_of(pc)] >= 2);
        e.req   = req;
        sb.push_back(e);
        @(posedge clk);
        if (uv) begin
            if (ut && model_cnt[uidx] < 3) model_cnt[uidx]++;
            if (!ut && model_cnt[uidx] > 0) model_cnt[uidx]--;
            model_hist = ((model_hist << 1) | int'(ut)) & MASK;
        end
    endtask

    // Monitor: compares outputs mid-cycle.
    always @(negedge clk) begin
        #3;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (pred_index !== e.idx) begin
                failures++;
                $display("FAIL %s pred_index actual=%0d expected=%0d", e.req, pred_index, e.idx);
            end
            checks++;
            if (pred_taken !== e.taken) begin
                failures++;
                $display("FAIL %s pred_taken actual=%0b expected=%0b", e.req, pred_taken, e.taken);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int held;
        logic [31:0] lfsr;
        for (int i = 0; i < DEPTH; i++) model_cnt[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5: reset state, raw PC slice index, not-taken everywhere.
        step(32'h0000_1234, 0, 0, 0, "R5");
        step(32'hFFFF_FFFF, 0, 0, 0, "R5");
        step(32'h8000_0003, 0, 0, 0, "R1");

        // R3 and R8: train entry 5 upward while looking it up in the same cycle.
        for (int i = 0; i < 5; i++) step(pc_for(5, 32'hA5A0_0003), 1, 5, 1, "R3_R8");
        step(pc_for(5, 0), 0, 0, 0, "R3");

        // R4: walk entry 5 down to the floor and past it.
        for (int i = 0; i < 5; i++) step(pc_for(5, 32'h0F00_0001), 1, 5, 0, "R4_R8");
        step(pc_for(5, 0), 1, 5, 1, "R4");
        step(pc_for(5, 0), 0, 0, 0, "R4");

        // R9: idle cycles change nothing.
        for (int i = 0; i < 4; i++) step(32'h0000_0400, 0, 0, 0, "R9");

        // R6: history movement seen through the index of a fixed PC.
        for (int i = 0; i < 8; i++) step(32'h0000_0400, 1, 9, logic'(i % 3 == 0), "R6");

        // R7: train an index captured before the history moved on.
        held = idx_of(32'h0000_0ABC);
        step(32'h0000_0ABC, 0, 0, 0, "R7");
        for (int i = 0; i < 3; i++) step(32'h0000_0100, 1, 17, 1, "R6");
        step(32'h0000_0ABC, 1, held, 1, "R7");
        step(32'h0000_0ABC, 1, held, 1, "R7");
        step(pc_for(held, 0), 0, 0, 0, "R7");

        // R2: mixed traffic, each update reuses the previous lookup index.
        lfsr = 32'hACE1_2345;
        held = idx_of(32'h0);
        for (int i = 0; i < 300; i++) begin
            logic [PC_W-1:0] pc;
            int nidx;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pc = {lfsr[15:0], lfsr[31:16]} & 32'h0000_00FC;
            nidx = idx_of(pc);
            step(pc, lfsr[3] | lfsr[9], held, lfsr[5] | lfsr[6], "R2");
            held = nidx;
        end

        @(negedge clk);
        #5;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule